// File: doc/BRIEF.md
# CAN Transceiver Supervisory Controller

This block is the digital control core of a high-speed CAN physical-layer transceiver. It sits between the protocol controller's transmit and receive bits and the analog line driver and comparators. It selects between an active mode and a low-power listening mode. It gates the line driver against supply faults, over-temperature and a transmit input held dominant for too long. It also picks the source of the receive bit for each mode.

In active mode the transmit bit drives the bus and the high-speed comparator is returned on the receive bit. In listening mode the driver, the high-speed comparator and the split reference are all off. The receive bit then shows the low-power receiver through a glitch filter, and a bus that stays dominant for too long stops pulling it low. After power-up or a supply dip, the driver stays quiet until the controller has shown a recessive transmit bit. This keeps a controller that is still in reset from blocking the bus.

Top module: `can_phy_ctrl`

## Requirements
- R1: With `stby_i`=0 (active mode), `hs_sel_o` and `split_en_o` are 1. `drv_en_o` is 1 unless R3, R5, R6 or R7 holds it off. With `stby_i`=1 (listening mode), `drv_en_o`, `hs_sel_o` and `split_en_o` are all 0.
- R2: While `drv_en_o`=1, `drv_dom_o` equals the inverse of `txd_i` (0 = dominant request). In active mode without undervoltage, `rxd_o` equals the inverse of `bus_dom_i`.
- R3: In active mode, once `txd_i` has been sampled 0 on TO_CYC consecutive clock edges, `drv_en_o` is 0. TO_CYC = CLK_HZ/800, which is 1.25 ms. It returns to 1 after the first edge that samples `txd_i`=1.
- R4: In listening mode, once `lp_dom_i` has been sampled 1 on TO_CYC consecutive edges, `rxd_o` is held at 1. The hold lasts until an edge samples `lp_dom_i`=0.
- R5: After reset, or after any undervoltage, `drv_en_o` stays 0 until an edge samples `txd_i`=1 with both undervoltage flags clear. It may be 1 from the cycle after that edge.
- R6: When `uv_core_i` or `uv_io_i` is 1, `drv_en_o` is 0 in the same cycle. In active mode `rxd_o` is also forced to 1.
- R7: `ot_i`=1 forces `drv_en_o` to 0 in the same cycle and changes no other output.
- R8: In listening mode, `rxd_o` goes to 0 only after `lp_dom_i` has been sampled 1 on WAKE_CYC consecutive edges. Shorter pulses leave `rxd_o` at 1.
- R9: An edge that samples a change of `stby_i` clears the transmit timeout lock, the bus timeout count and the wake filter count.
- R10: While `rst_ni`=0, `drv_en_o` and `drv_dom_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Transmit bit, 0 = dominant |
| stby_i | input | 1 | 1 = listening mode, 0 = active mode |
| bus_dom_i | input | 1 | High-speed comparator, 1 = bus dominant |
| lp_dom_i | input | 1 | Low-power receiver, 1 = bus dominant |
| uv_core_i | input | 1 | Core supply undervoltage |
| uv_io_i | input | 1 | I/O supply undervoltage |
| ot_i | input | 1 | Over-temperature |
| drv_en_o | output | 1 | Line driver enable |
| drv_dom_o | output | 1 | Line driver dominant request |
| rxd_o | output | 1 | Receive bit, 0 = dominant |
| hs_sel_o | output | 1 | 1 = high-speed receiver selected |
| split_en_o | output | 1 | Split reference enable |

## Verification
The assertions check the relations that hold at every clock. In listening mode the driver and split reference are off. A dominant request only comes with an enabled driver and a low transmit bit. Undervoltage forces the receive bit recessive in active mode. Over-temperature blocks the driver. The interlock arms only after seeing a recessive transmit bit, and the counters stay within their limits.

Some behaviours depend on history, and only the bench scenarios can show them. These are:
- the exact edge on which the two timeouts fire and release;
- suppression of wake pulses shorter than the filter length;
- clearing of the locks when the mode flips;
- re-arming after a supply dip with the transmit bit still low.

// File: rtl/can_phy_pkg.sv
package can_phy_pkg;
  typedef enum logic {MODE_NORMAL = 1'b0, MODE_STBY = 1'b1} mode_e;

  // cycles in 1.25 ms
  function automatic int unsigned stuck_cycles(int unsigned clk_hz);
    return clk_hz / 800;
  endfunction
endpackage

// File: rtl/can_phy_sat_cnt.sv
module can_phy_sat_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic hit_o
);
  localparam int unsigned   CW  = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !run_i)   cnt_q <= '0;
    else if (cnt_q != LIM)      cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == LIM);

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  assert_clr_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  assert_hit_needs_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_o) |-> $past(run_i && !clr_i));
endmodule

// File: rtl/can_phy_arm.sv
module can_phy_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic uv_i,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            armed_q <= 1'b0;
    else if (uv_i)          armed_q <= 1'b0;
    else if (txd_i)         armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  assert_arm_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(txd_i && !uv_i));
  assert_arm_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> !armed_q);
endmodule

// File: rtl/can_phy_ctrl.sv
module can_phy_ctrl
  import can_phy_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned WAKE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic stby_i,
  input  logic bus_dom_i,
  input  logic lp_dom_i,
  input  logic uv_core_i,
  input  logic uv_io_i,
  input  logic ot_i,
  output logic drv_en_o,
  output logic drv_dom_o,
  output logic rxd_o,
  output logic hs_sel_o,
  output logic split_en_o
);
  localparam int unsigned TO_CYC = stuck_cycles(CLK_HZ);

  mode_e mode, mode_q;
  logic  normal, mode_chg, uv, armed;
  logic  tx_lock, bus_lock, wake_dom;

  assign mode     = mode_e'(stby_i);
  assign normal   = (mode == MODE_NORMAL);
  assign uv       = uv_core_i | uv_io_i;
  assign mode_chg = (mode != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_STBY;
    else         mode_q <= mode;
  end

  can_phy_arm u_arm (
    .clk_i, .rst_ni, .txd_i, .uv_i(uv), .armed_o(armed)
  );

  // stuck transmit: saturated count is the lock
  can_phy_sat_cnt #(.LIMIT(TO_CYC)) u_tx_to (
    .clk_i, .rst_ni, .clr_i(mode_chg), .run_i(normal && !txd_i), .hit_o(tx_lock)
  );

  // stuck bus in standby
  can_phy_sat_cnt #(.LIMIT(TO_CYC)) u_bus_to (
    .clk_i, .rst_ni, .clr_i(mode_chg), .run_i(!normal && lp_dom_i), .hit_o(bus_lock)
  );

  // wake-up glitch filter
  can_phy_sat_cnt #(.LIMIT(WAKE_CYC)) u_wake (
    .clk_i, .rst_ni, .clr_i(mode_chg), .run_i(!normal && lp_dom_i), .hit_o(wake_dom)
  );

  assign drv_en_o   = normal && armed && !uv && !ot_i && !tx_lock;
  assign drv_dom_o  = drv_en_o && !txd_i;
  assign hs_sel_o   = normal;
  assign split_en_o = normal;

  always_comb begin
    if (normal) rxd_o = uv ? 1'b1 : !bus_dom_i;
    else        rxd_o = !(wake_dom && !bus_lock);
  end

  assert_stby_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |-> (!drv_en_o && !split_en_o && !hs_sel_o));
  assert_dom_txd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_dom_o |-> (!txd_i && drv_en_o));
  assert_uv_rxd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stby_i && (uv_core_i || uv_io_i)) |-> (rxd_o && !drv_en_o));
  assert_ot_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |-> !drv_en_o);
  assert_lock_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stby_i && $past(!stby_i) && $past(txd_i)) |-> !tx_lock);
endmodule

// File: tb/can_phy_ctrl_tb_top.sv
`timescale 1ns/100ps
module can_phy_ctrl_tb_top;
  localparam int unsigned CLK_HZ = 16_000;
  localparam int unsigned TO     = CLK_HZ / 800;  // 20
  localparam int unsigned WK     = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txd = 1'b1, stby = 1'b0, bus_dom = 1'b0, lp_dom = 1'b0;
  logic uvc = 1'b0, uvi = 1'b0, ot = 1'b0;
  logic drv_en, drv_dom, rxd, hs_sel, split_en;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_phy_ctrl #(.CLK_HZ(CLK_HZ), .WAKE_CYC(WK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .txd_i(txd), .stby_i(stby), .bus_dom_i(bus_dom),
    .lp_dom_i(lp_dom), .uv_core_i(uvc), .uv_io_i(uvi), .ot_i(ot),
    .drv_en_o(drv_en), .drv_dom_o(drv_dom), .rxd_o(rxd), .hs_sel_o(hs_sel),
    .split_en_o(split_en)
  );

  // reference state, built from the requirements
  bit m_armed, m_prev_stby;
  int m_tx, m_bus, m_wk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_prev_stby = 1; m_tx = 0; m_bus = 0; m_wk = 0;
    end else begin
      bit chg;
      chg = (stby != m_prev_stby);
      m_tx  = (chg || stby || txd)    ? 0 : ((m_tx  < TO) ? m_tx + 1  : m_tx);
      m_bus = (chg || !stby || !lp_dom) ? 0 : ((m_bus < TO) ? m_bus + 1 : m_bus);
      m_wk  = (chg || !stby || !lp_dom) ? 0 : ((m_wk  < WK) ? m_wk + 1  : m_wk);
      if (uvc || uvi) m_armed = 0;
      else if (txd)   m_armed = 1;
      m_prev_stby = stby;
    end
  end

  function automatic bit exp_en();
    return !stby && m_armed && !(uvc || uvi) && !ot && (m_tx != TO) && rst_n;
  endfunction

  function automatic bit exp_rxd();
    if (!stby) return (uvc || uvi) ? 1'b1 : !bus_dom;
    return !((m_wk == WK) && (m_bus != TO));
  endfunction

  task automatic cmp(string req, string nm, logic act, logic exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic step(string req);
    bit e;
    #1;
    vectors++;
    e = exp_en();
    cmp(req, "drv_en", drv_en, e);
    cmp(req, "drv_dom", drv_dom, e && !txd);
    if (rst_n) begin
      cmp(req, "rxd", rxd, exp_rxd());
      cmp(req, "hs_sel", hs_sel, !stby);
      cmp(req, "split_en", split_en, !stby);
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // R10: outputs quiet in reset
    txd = 0;
    repeat (3) step("R10");
    rst_n = 1'b1;
    // R5: released with txd low, no arming
    repeat (5) step("R5");
    txd = 1; step("R5");
    step("R5");   // armed now
    // R2: active data path
    for (int i = 0; i < 8; i++) begin
      txd = i[0]; bus_dom = i[1]; step("R2");
    end
    // R3: stuck transmit and release
    txd = 0;
    repeat (TO + 4) step("R3");
    txd = 1; step("R3"); step("R3");
    // R9: mode flip clears the lock
    txd = 0;
    repeat (TO + 2) step("R9");
    stby = 1; step("R9");
    stby = 0; step("R9"); step("R9");
    txd = 1; step("R9");
    // R6: undervoltage, then re-arm with txd low
    uvc = 1; bus_dom = 1; step("R6"); step("R6");
    uvc = 0; txd = 0; repeat (3) step("R6");
    uvi = 1; step("R6"); uvi = 0; step("R5");
    txd = 1; step("R5"); step("R5");
    // R7: over-temperature
    ot = 1; txd = 0; bus_dom = 1; step("R7"); bus_dom = 0; step("R7");
    ot = 0; step("R7");
    txd = 1; step("R7");
    // R1 / R8: standby, short pulse filtered
    stby = 1; lp_dom = 0; step("R1"); step("R1");
    lp_dom = 1; repeat (WK - 1) step("R8");
    lp_dom = 0; step("R8"); step("R8");
    lp_dom = 1; repeat (WK + 2) step("R8");
    // R4: stuck bus in standby, release on recessive
    repeat (TO) step("R4");
    lp_dom = 0; step("R4"); step("R4");
    lp_dom = 1; repeat (WK + 1) step("R4");
    lp_dom = 0; stby = 0; step("R1");
    txd = 1; step("R1");

    // constrained random segments
    for (int s = 0; s < 300; s++) begin
      int len;
      bit hold_tx, hold_lp;
      len = 1 + ($urandom % 40);
      stby = ($urandom % 4) == 0;
      hold_tx = ($urandom % 3) == 0;
      hold_lp = ($urandom % 3) == 0;
      uvc = ($urandom % 16) == 0;
      uvi = ($urandom % 20) == 0;
      ot  = ($urandom % 16) == 0;
      for (int c = 0; c < len; c++) begin
        txd     = hold_tx ? 1'b0 : 1'($urandom % 2);
        lp_dom  = hold_lp ? 1'b1 : 1'($urandom % 2);
        bus_dom = 1'($urandom % 2);
        step("R2");
      end
    end
    finish_run();
  end
endmodule